// File: doc/BRIEF.md
# Doorbell and Interrupt Register Block

This block is the small register file of a shared-memory device that links several processing nodes. Software on the local node sees four 32-bit words: an interrupt enable mask, an interrupt status word, a read-only word that reports the node's own slot number, and a write-only doorbell. Writing the doorbell asks the block to signal a chosen vector of a chosen remote node. The block checks the request against the live node count and against a per-node vector-count table supplied from outside. It then either emits a single-clock pulse on one line of a flattened node-by-vector notify bus, or drops the request without any trace.

In the legacy interrupt scheme, an incoming event for this node loads the status word with the value 1. A level interrupt line follows the AND of status and mask. Reading the status word returns it and zeroes it in the same access, so a handler acknowledges an interrupt by reading it. When message-signalled interrupts are selected, or when the node has no interrupt pin, the level line stays low.

Top module: `dbell_regblk`

## Requirements
- R1: While `rst` is high, the mask and status words are forced to zero, and `irq_o`, `notify_o` and `bus_rdata` are low. The first reads after reset return zero from both words.
- R2: A read presented with `bus_re` at a clock edge returns its data on `bus_rdata` after that edge. Address 0x00 returns the mask, 0x04 the status word, and 0x08 the own slot number zero-extended from `own_id_i`. Address 0x0C and every other address, including unaligned ones, return zero.
- R3: Writes decode `bus_addr & 8'hFC`. A write to the mask or status word replaces all 32 bits.
- R4: A read of address 0x04 returns the status value held before the access and leaves the status word at zero.
- R5: `irq_o` is registered. After each edge it is high exactly when the status word AND the mask word (both as updated at that edge) is nonzero, `msi_mode_i` is low and `pin_present_i` is high.
- R6: For a doorbell write (decoded address 0x0C), the destination node is `bus_wdata[31:16]` and the vector is `bus_wdata[7:0]`; bits 15:8 are ignored. A valid request raises bit `node*VEC_PER_PEER + vector` of `notify_o` for exactly the one cycle after the write edge. A doorbell write leaves the mask and status words unchanged.
- R7: A doorbell whose destination is not below `peer_count_i`, or not below `NUM_PEERS`, produces no pulse.
- R8: A doorbell whose vector is not below the target node's entry in `vec_count_i` produces no pulse. Node p's count occupies bits `[p*CNT_W +: CNT_W]`, where `CNT_W = $clog2(VEC_PER_PEER+1)`.
- R9: With `msi_mode_i` low, a high `local_event_i` at an edge sets the status word to exactly 1. This takes priority over a bus write or read-clear of the status word in the same cycle. With `msi_mode_i` high, the event is ignored.
- R10: At most one bit of `notify_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address within the block |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| own_id_i | input | 16 | This node's slot number |
| peer_count_i | input | 16 | Number of nodes currently present |
| vec_count_i | input | NUM_PEERS*CNT_W | Registered vector count per node |
| msi_mode_i | input | 1 | Message-signalled interrupts selected |
| pin_present_i | input | 1 | Legacy interrupt pin is configured |
| local_event_i | input | 1 | Incoming event for this node |
| notify_o | output | NUM_PEERS*VEC_PER_PEER | One-cycle notify pulse per node and vector |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench sends doorbells just past each limit: a node equal to the live count, a node beyond the parameter, a vector equal to a node's count, and a node with zero vectors. A design that compared with less-or-equal, or indexed the wrong count field, would emit a stray pulse. It reads status twice and checks the gated interrupt line around the read, so a design that never clears, or clears without dropping the line, is caught. It also drives an event and a status write in the same cycle, and uses an unaligned write address, to expose a reversed priority or a write decode that skips the low-bit mask.

// File: rtl/dbell_pkg.sv
package dbell_pkg;
  localparam int REG_W = 32;
  localparam int ADDR_W = 8;
  localparam int PID_W = 16;
  localparam int VEC_W = 8;
  localparam logic [ADDR_W-1:0] WORD_MASK = 8'hFC;
  localparam logic [ADDR_W-1:0] OFS_MASK = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_ID   = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_BELL = 8'h0C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MASK,
    SEL_STAT,
    SEL_ID,
    SEL_BELL
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
    case (a)
      OFS_MASK: decode_addr = SEL_MASK;
      OFS_STAT: decode_addr = SEL_STAT;
      OFS_ID:   decode_addr = SEL_ID;
      OFS_BELL: decode_addr = SEL_BELL;
      default:  decode_addr = SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/dbell_decode.sv
module dbell_decode #(
  parameter int NUM_PEERS    = 4,
  parameter int VEC_PER_PEER = 4,
  parameter int CNT_W        = $clog2(VEC_PER_PEER + 1),
  parameter int IDX_W        = 4
) (
  input  logic                       fire,
  input  logic [31:0]                wdata,
  input  logic [15:0]                peer_count_i,
  input  logic [NUM_PEERS*CNT_W-1:0] vec_count_i,
  output logic                       hit,
  output logic [IDX_W-1:0]           idx
);
  logic [15:0] dest;
  logic [7:0]  vec;
  logic [CNT_W-1:0] cnt [NUM_PEERS];
  logic dest_ok, vec_ok;
  logic [7:0] unused_mid;

  assign dest = wdata[31:16];
  assign vec  = wdata[7:0];
  assign unused_mid = wdata[15:8];

  for (genvar p = 0; p < NUM_PEERS; p++) begin : g_cnt
    assign cnt[p] = vec_count_i[p*CNT_W +: CNT_W];
  end

  always_comb begin
    dest_ok = (dest < peer_count_i) && (32'(dest) < 32'(NUM_PEERS));
    vec_ok  = 1'b0;
    for (int p = 0; p < NUM_PEERS; p++) begin
      if (32'(dest) == 32'(p) && 32'(vec) < 32'(cnt[p]) &&
          32'(vec) < 32'(VEC_PER_PEER))
        vec_ok = 1'b1;
    end
  end

  assign hit = fire && dest_ok && vec_ok;
  assign idx = IDX_W'(32'(dest) * 32'(VEC_PER_PEER) + 32'(vec));
endmodule

// File: rtl/dbell_notify.sv
module dbell_notify #(
  parameter int NOTE_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit,
  input  logic [IDX_W-1:0]  idx,
  output logic [NOTE_W-1:0] notify_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      notify_o <= '0;
    end else begin
      notify_o <= '0;
      if (hit) notify_o[idx] <= 1'b1;
    end
  end

  assert_notify_onehot_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(notify_o));

  assert_notify_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    (notify_o != '0) |=> (notify_o == '0) || $past(hit));
endmodule

// File: rtl/dbell_irq_regs.sv
module dbell_irq_regs #(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mask_we,
  input  logic             stat_we,
  input  logic             stat_rd,
  input  logic [REG_W-1:0] wdata,
  input  logic             event_i,
  input  logic             msi_mode_i,
  input  logic             pin_present_i,
  output logic [REG_W-1:0] mask_q,
  output logic [REG_W-1:0] stat_q,
  output logic             irq_o
);
  logic [REG_W-1:0] mask_d, stat_d;
  logic ev_eff;

  assign ev_eff = event_i && !msi_mode_i;

  always_comb begin
    mask_d = mask_we ? wdata : mask_q;
    stat_d = stat_q;
    if (stat_rd) stat_d = '0;
    if (stat_we) stat_d = wdata;
    if (ev_eff)  stat_d = REG_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      stat_q <= '0;
      irq_o  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      stat_q <= stat_d;
      irq_o  <= (|(stat_d & mask_d)) && !msi_mode_i && pin_present_i;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mask_q == '0 && stat_q == '0));

  assert_read_clears_R4: assert property (@(posedge clk) disable iff (rst)
    $past(stat_rd && !stat_we && !ev_eff) |-> (stat_q == '0));

  assert_irq_gated_R5: assert property (@(posedge clk) disable iff (rst)
    $past(msi_mode_i || !pin_present_i) |-> !irq_o);

  assert_irq_level_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (stat_q & mask_q) == '0) |-> !irq_o);

  assert_event_sets_R9: assert property (@(posedge clk) disable iff (rst)
    $past(event_i && !msi_mode_i) |-> (stat_q == REG_W'(1)));
endmodule

// File: rtl/dbell_regblk.sv
module dbell_regblk #(
  parameter int NUM_PEERS    = 4,
  parameter int VEC_PER_PEER = 4,
  parameter int CNT_W        = $clog2(VEC_PER_PEER + 1),
  parameter int NOTE_W       = NUM_PEERS * VEC_PER_PEER
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_we,
  input  logic                       bus_re,
  input  logic [7:0]                 bus_addr,
  input  logic [31:0]                bus_wdata,
  output logic [31:0]                bus_rdata,
  input  logic [15:0]                own_id_i,
  input  logic [15:0]                peer_count_i,
  input  logic [NUM_PEERS*CNT_W-1:0] vec_count_i,
  input  logic                       msi_mode_i,
  input  logic                       pin_present_i,
  input  logic                       local_event_i,
  output logic [NOTE_W-1:0]          notify_o,
  output logic                       irq_o
);
  import dbell_pkg::*;

  localparam int IDX_W = (NOTE_W > 1) ? $clog2(NOTE_W) : 1;

  reg_sel_e wsel, rsel;
  logic [REG_W-1:0] mask_q, stat_q;
  logic bell_hit;
  logic [IDX_W-1:0] bell_idx;

  assign wsel = bus_we ? decode_addr(bus_addr & WORD_MASK) : SEL_NONE;
  assign rsel = bus_re ? decode_addr(bus_addr) : SEL_NONE;

  dbell_irq_regs #(.REG_W(REG_W)) u_irq (
    .clk           (clk),
    .rst           (rst),
    .mask_we       (wsel == SEL_MASK),
    .stat_we       (wsel == SEL_STAT),
    .stat_rd       (rsel == SEL_STAT),
    .wdata         (bus_wdata),
    .event_i       (local_event_i),
    .msi_mode_i    (msi_mode_i),
    .pin_present_i (pin_present_i),
    .mask_q        (mask_q),
    .stat_q        (stat_q),
    .irq_o         (irq_o)
  );

  dbell_decode #(
    .NUM_PEERS    (NUM_PEERS),
    .VEC_PER_PEER (VEC_PER_PEER),
    .CNT_W        (CNT_W),
    .IDX_W        (IDX_W)
  ) u_dec (
    .fire         (wsel == SEL_BELL),
    .wdata        (bus_wdata),
    .peer_count_i (peer_count_i),
    .vec_count_i  (vec_count_i),
    .hit          (bell_hit),
    .idx          (bell_idx)
  );

  dbell_notify #(.NOTE_W(NOTE_W), .IDX_W(IDX_W)) u_note (
    .clk      (clk),
    .rst      (rst),
    .hit      (bell_hit),
    .idx      (bell_idx),
    .notify_o (notify_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (rsel)
        SEL_MASK: bus_rdata <= mask_q;
        SEL_STAT: bus_rdata <= stat_q;
        SEL_ID:   bus_rdata <= {16'h0, own_id_i};
        default:  bus_rdata <= '0;
      endcase
    end
  end

  assert_notify_cause_R6: assert property (@(posedge clk) disable iff (rst)
    (notify_o != '0) |-> $past(bus_we && ((bus_addr & WORD_MASK) == OFS_BELL)));

  assert_unused_read_zero_R2: assert property (@(posedge clk) disable iff (rst)
    $past(bus_re && bus_addr != OFS_MASK && bus_addr != OFS_STAT &&
          bus_addr != OFS_ID) |-> (bus_rdata == '0));
endmodule

// File: tb/dbell_regblk_tb.sv
module dbell_regblk_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int VP = 4;
  localparam int CW = $clog2(VP + 1);
  localparam int NW = NP * VP;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] own_id_i = 16'h0002;
  logic [15:0] peer_count_i = 16'd3;
  logic [NP*CW-1:0] vec_count_i;
  logic msi_mode_i = 1'b0, pin_present_i = 1'b1, local_event_i = 1'b0;
  logic [NW-1:0] notify_o;
  logic irq_o;

  int n_chk = 0, n_bad = 0;

  // node 0: 4 vectors, node 1: 2, node 2: 0, node 3: 3
  assign vec_count_i = {3'd3, 3'd0, 3'd2, 3'd4};

  always #(CLK_PERIOD/2) clk = ~clk;

  dbell_regblk #(.NUM_PEERS(NP), .VEC_PER_PEER(VP)) u_dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .own_id_i(own_id_i), .peer_count_i(peer_count_i),
    .vec_count_i(vec_count_i), .msi_mode_i(msi_mode_i),
    .pin_present_i(pin_present_i), .local_event_i(local_event_i),
    .notify_o(notify_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 notify", 32'(notify_o), 0);
    chk("R1 rdata", bus_rdata, 0);
    rd(8'h00, v); chk("R1 mask", v, 0);
    rd(8'h04, v); chk("R1 status", v, 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(8'h00, 32'hA5A5_0003);
    rd(8'h00, v); chk("R2 R3 mask readback", v, 32'hA5A5_0003);
    rd(8'h08, v); chk("R2 own id", v, 32'h0000_0002);
    rd(8'h0C, v); chk("R2 doorbell reads zero", v, 0);
    rd(8'h10, v); chk("R2 unused reads zero", v, 0);
    rd(8'h01, v); chk("R2 unaligned read zero", v, 0);
    wr(8'h01, 32'h0000_00F0);
    rd(8'h00, v); chk("R3 masked write addr", v, 32'h0000_00F0);
  endtask

  task automatic t_irq();
    wr(8'h04, 32'h0000_000F); chk("R5 no overlap", 32'(irq_o), 0);
    wr(8'h06, 32'h0000_0010); chk("R5 overlap", 32'(irq_o), 1);
    msi_mode_i = 1'b1; idle(); chk("R5 msi gate", 32'(irq_o), 0);
    msi_mode_i = 1'b0; idle(); chk("R5 msi off", 32'(irq_o), 1);
    pin_present_i = 1'b0; idle(); chk("R5 no pin", 32'(irq_o), 0);
    pin_present_i = 1'b1; idle(); chk("R5 pin back", 32'(irq_o), 1);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    rd(8'h04, v); chk("R4 read value", v, 32'h0000_0010);
    chk("R4 irq drops", 32'(irq_o), 0);
    rd(8'h04, v); chk("R4 cleared", v, 0);
  endtask

  task automatic t_event();
    logic [31:0] v;
    wr(8'h00, 32'h0000_0001);
    wr(8'h04, 32'h0000_0006);
    @(negedge clk); local_event_i = 1'b1;
    @(negedge clk); local_event_i = 1'b0;
    chk("R9 irq on event", 32'(irq_o), 1);
    rd(8'h04, v); chk("R9 event sets 1", v, 1);
    msi_mode_i = 1'b1;
    @(negedge clk); local_event_i = 1'b1;
    @(negedge clk); local_event_i = 1'b0;
    msi_mode_i = 1'b0;
    rd(8'h04, v); chk("R9 ignored in msi", v, 0);
    @(negedge clk);
    local_event_i = 1'b1; bus_we = 1'b1; bus_addr = 8'h04; bus_wdata = 32'h8;
    @(negedge clk);
    local_event_i = 1'b0; bus_we = 1'b0;
    rd(8'h04, v); chk("R9 event beats write", v, 1);
  endtask

  task automatic bell(input string req, input logic [31:0] d,
                      input logic [NW-1:0] exp);
    wr(8'h0C, d);
    chk(req, 32'(notify_o), 32'(exp));
    idle();
    chk({req, " pulse ends"}, 32'(notify_o), 0);
  endtask

  task automatic t_bell();
    logic [31:0] v;
    wr(8'h00, 32'h1234_5678);
    bell("R6 node1 vec1", 32'h0001_0001, NW'(1) << 5);
    bell("R6 mid bits ignored", 32'h0000_FF03, NW'(1) << 3);
    bell("R7 node eq count", 32'h0003_0000, '0);
    bell("R7 node far", 32'h0100_0000, '0);
    bell("R8 vec eq count", 32'h0001_0002, '0);
    bell("R8 zero vectors", 32'h0002_0000, '0);
    peer_count_i = 16'd4;
    bell("R7 node3 after count", 32'h0003_0002, NW'(1) << 14);
    bell("R8 node3 vec3", 32'h0003_0003, '0);
    bell("R10 node0 vec0", 32'h0000_0000, NW'(1));
    rd(8'h00, v); chk("R6 mask kept", v, 32'h1234_5678);
    rd(8'h04, v); chk("R6 status kept", v, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_irq();
    t_clear();
    t_event();
    t_bell();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule